// File: doc/BRIEF.md
# Timestamped Transmit Sample Scheduler

This block sits between a DMA stream of transmit I/Q samples and a DAC sample interface. Software sends each burst of samples as a packet. The packet opens with two fixed marker words, then a 64-bit timestamp and a sample count. The scheduler finds each packet by its markers and stores its samples in one of several packet buffers. Buffers are filled and drained in round-robin order. The block then hands the samples to the DAC so that the first sample lines up with the sample-clock count named by the timestamp.

A free-running 64-bit sample counter advances on a one-cycle sample strobe, which runs in the same clock domain as the stream. A packet that arrives early is held back, and zeros go out until its time comes. If a packet is late, the overdue leading samples are skipped and output starts partway into the buffer. A packet whose lateness reaches its own length is thrown away. For each packet the block reports whether it was early or late and by how much. An underflow flag shows every strobe on which nothing was due. A control input turns timestamping off, and packets are then forwarded as soon as they are at the head of the queue.

Top module: `tx_time_sched`

## Requirements
- R1: The stream is 32-bit words, each taken on a cycle where valid and ready are both high; each word holds one sample, with I in bits 31:16 and Q in bits 15:0. A packet is the word 32'h7E57C0DE, then 32'h5A4D1E11, then timestamp bits 31:0, then timestamp bits 63:32, then the sample count N, then N samples. Words that arrive outside a complete packet, including a lone first marker followed by another word, are discarded.
- R2: A count of 0, or a count above MAX_LEN, cancels that header: no packet is stored and the marker search starts again.
- R3: When timestamping is on, sample k of a packet with timestamp T appears on `dac_iq` on the strobe that moves `time_now` to T+k. Until then `dac_iq` is zero. All N samples then follow on consecutive strobes.
- R4: If a late packet first reaches the head of the queue on the strobe that moves `time_now` to t, and t > T with t-T < N, then that strobe outputs sample t-T and the rest of the packet follows.
- R5: If t-T >= N, that strobe outputs zero and releases the packet. The next queued packet is then considered on the very next strobe.
- R6: With `ts_enable` low, a packet at the head of the queue outputs its sample 0 on the next strobe, whatever its timestamp.
- R7: On the first strobe that finds a packet at the head, the flags are set. `pkt_early` is set with `pkt_diff`=T-t if T>t. `pkt_late` is set with `pkt_diff`=t-T if T<t. Both flags are cleared with `pkt_diff`=0 if T=t or timestamping is off. The flags hold until the next packet is classified.
- R8: After every strobe that outputs zero fill, `underflow` is 1. After every strobe that outputs a sample, it is 0.
- R9: Packets are played in arrival order. A packet queued behind another starts on the strobe right after the last sample of the one ahead, when both are due.
- R10: `s_tready` is low while all NUM_BUF buffers hold packets. It is high again in the cycle after a buffer is released.
- R11: After reset, `time_now`, `dac_iq`, `underflow`, `pkt_early`, `pkt_late` and `pkt_diff` are all zero, and `s_tready` is 1.
- R12: `time_now` rises by exactly one on each clock edge where `sample_en` is high, and it holds on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stream and the scheduler |
| rst | input | 1 | Synchronous active-high reset |
| ts_enable | input | 1 | 1: playout follows the timestamps; 0: forward packets as soon as possible |
| s_tdata | input | 32 | Stream word |
| s_tvalid | input | 1 | Stream word valid |
| s_tready | output | 1 | Stream ready; low while every buffer is full |
| sample_en | input | 1 | One-cycle strobe for each DAC sample period |
| dac_iq | output | 32 | Sample for the current `time_now` value |
| time_now | output | 64 | Free-running sample counter |
| underflow | output | 1 | The last strobe had no sample due |
| pkt_early | output | 1 | The last classified packet was early |
| pkt_late | output | 1 | The last classified packet was late |
| pkt_diff | output | 64 | Size of that packet's timing error, in samples |

## Verification
Every output that depends on time is registered on the strobe edge. `dac_iq`, `underflow`, the packet flags and `time_now` therefore take their new values one edge after `sample_en` is seen high. The bench raises the strobe for one cycle and reads the outputs on the next falling edge. `s_tready` follows buffer occupancy after one register. It drops at the falling edge after the edge that accepted the last sample of the final free buffer, and it rises right after the strobe that releases a buffer. The expected sample for each strobe is computed from the bench's own copy of the counter, the packet's timestamp and its length. That gives a one-to-one expected value for every strobe, early, late, discarded and random packets alike.

// File: rtl/tx_sched_pkg.sv
package tx_sched_pkg;

    localparam logic [31:0] HDR_WORD_A = 32'h7E57_C0DE;
    localparam logic [31:0] HDR_WORD_B = 32'h5A4D_1E11;

    typedef enum logic [2:0] {
        PS_HUNT_A,
        PS_HUNT_B,
        PS_TS_LO,
        PS_TS_HI,
        PS_LEN,
        PS_DATA
    } parse_state_e;

    typedef struct packed {
        logic [63:0] ts;
        logic [31:0] len;
    } pkt_meta_t;

    typedef enum logic [1:0] {
        CLS_ON_TIME,
        CLS_EARLY,
        CLS_LATE
    } pkt_class_e;

    function automatic logic [63:0] time_gap(input logic [63:0] a, input logic [63:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/txs_frame_parser.sv
module txs_frame_parser
    import tx_sched_pkg::*;
#(
    parameter int MAX_LEN = 512,
    localparam int ADDR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tready,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [31:0]       wr_data,
    output logic              commit,
    output pkt_meta_t         commit_meta
);

    parse_state_e state_q;
    logic [31:0]  ts_lo_q;
    logic [31:0]  ts_hi_q;
    logic [31:0]  len_q;
    logic [31:0]  idx_q;
    logic         take;
    logic         len_ok;

    assign take   = s_tvalid && s_tready;
    assign len_ok = (s_tdata != 32'd0) && (s_tdata <= 32'(MAX_LEN));

    assign wr_en   = take && (state_q == PS_DATA);
    assign wr_addr = idx_q[ADDR_W-1:0];
    assign wr_data = s_tdata;
    assign commit  = wr_en && (idx_q == len_q - 32'd1);
    assign commit_meta.ts  = {ts_hi_q, ts_lo_q};
    assign commit_meta.len = len_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PS_HUNT_A;
            ts_lo_q <= '0;
            ts_hi_q <= '0;
            len_q   <= '0;
            idx_q   <= '0;
        end else if (take) begin
            case (state_q)
                PS_HUNT_A: if (s_tdata == HDR_WORD_A) state_q <= PS_HUNT_B;
                PS_HUNT_B: begin
                    if (s_tdata == HDR_WORD_B)      state_q <= PS_TS_LO;
                    else if (s_tdata != HDR_WORD_A) state_q <= PS_HUNT_A;
                end
                PS_TS_LO: begin
                    ts_lo_q <= s_tdata;
                    state_q <= PS_TS_HI;
                end
                PS_TS_HI: begin
                    ts_hi_q <= s_tdata;
                    state_q <= PS_LEN;
                end
                PS_LEN: begin
                    idx_q <= '0;
                    if (len_ok) begin
                        len_q   <= s_tdata;
                        state_q <= PS_DATA;
                    end else begin
                        state_q <= PS_HUNT_A;
                    end
                end
                PS_DATA: begin
                    if (commit) begin
                        idx_q   <= '0;
                        state_q <= PS_HUNT_A;
                    end else begin
                        idx_q <= idx_q + 32'd1;
                    end
                end
                default: state_q <= PS_HUNT_A;
            endcase
        end
    end

    a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
        commit |-> (commit_meta.len != 32'd0 && commit_meta.len <= 32'(MAX_LEN)));

    a_r1_data_in_bounds: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (idx_q < len_q));

endmodule

// File: rtl/txs_slot_bank.sv
module txs_slot_bank
    import tx_sched_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int MAX_LEN = 512,
    localparam int ADDR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
    localparam int SLOT_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              commit,
    input  pkt_meta_t         commit_meta,
    output logic              wr_full,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              release_head,
    output logic              head_full,
    output pkt_meta_t         head_meta,
    output logic [31:0]       rd_data
);

    logic [NUM_BUF-1:0] full_q;
    logic [SLOT_W-1:0]  wr_ptr_q;
    logic [SLOT_W-1:0]  rd_ptr_q;
    pkt_meta_t          meta_q [NUM_BUF];
    logic [31:0]        slot_rd [NUM_BUF];

    function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] p);
        return (p == SLOT_W'(NUM_BUF - 1)) ? '0 : p + SLOT_W'(1);
    endfunction

    generate
        for (genvar g = 0; g < NUM_BUF; g++) begin : g_slot
            logic [31:0] mem [MAX_LEN];

            always_ff @(posedge clk) begin
                if (wr_en && wr_ptr_q == SLOT_W'(g)) mem[wr_addr] <= wr_data;
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    full_q[g] <= 1'b0;
                    meta_q[g] <= '0;
                end else begin
                    if (commit && wr_ptr_q == SLOT_W'(g)) begin
                        full_q[g] <= 1'b1;
                        meta_q[g] <= commit_meta;
                    end else if (release_head && rd_ptr_q == SLOT_W'(g)) begin
                        full_q[g] <= 1'b0;
                    end
                end
            end

            assign slot_rd[g] = mem[rd_addr];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (commit)       wr_ptr_q <= next_slot(wr_ptr_q);
            if (release_head) rd_ptr_q <= next_slot(rd_ptr_q);
        end
    end

    assign wr_full   = full_q[wr_ptr_q];
    assign head_full = full_q[rd_ptr_q];
    assign head_meta = meta_q[rd_ptr_q];
    assign rd_data   = slot_rd[rd_ptr_q];

    a_r10_stall_when_full: assert property (@(posedge clk) disable iff (rst)
        ($countones(full_q) == NUM_BUF) |-> wr_full);

    a_r9_no_overwrite: assert property (@(posedge clk) disable iff (rst)
        commit |-> !full_q[wr_ptr_q]);

    a_r9_release_only_full: assert property (@(posedge clk) disable iff (rst)
        release_head |-> head_full);

endmodule

// File: rtl/txs_playout.sv
module txs_playout
    import tx_sched_pkg::*;
#(
    parameter int MAX_LEN = 512,
    localparam int ADDR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ts_enable,
    input  logic              sample_en,
    input  logic              head_full,
    input  pkt_meta_t         head_meta,
    input  logic [31:0]       rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              release_head,
    output logic [31:0]       dac_iq,
    output logic [63:0]       time_now,
    output logic              underflow,
    output logic              pkt_early,
    output logic              pkt_late,
    output logic [63:0]       pkt_diff
);

    logic [63:0] cnt_q;
    logic [31:0] idx_q;
    logic        started_q;
    logic        classified_q;
    logic [31:0] dac_q;
    logic        uf_q;
    pkt_class_e  cls_q;
    logic [63:0] diff_q;

    logic [63:0] t_next;
    logic        due;
    logic [63:0] offset;
    logic        drop;
    logic        at_last;
    pkt_class_e  cls_now;

    always_comb begin
        t_next  = cnt_q + 64'd1;
        due     = !ts_enable || (head_meta.ts <= t_next);
        offset  = ts_enable ? (t_next - head_meta.ts) : 64'd0;
        drop    = due && (offset >= {32'd0, head_meta.len});
        at_last = started_q ? (idx_q == head_meta.len - 32'd1)
                            : (offset == {32'd0, head_meta.len - 32'd1});
        rd_addr = started_q ? idx_q[ADDR_W-1:0] : offset[ADDR_W-1:0];
        if (!ts_enable || head_meta.ts == t_next) cls_now = CLS_ON_TIME;
        else if (head_meta.ts > t_next)           cls_now = CLS_EARLY;
        else                                       cls_now = CLS_LATE;
        release_head = sample_en && head_full &&
                       (started_q ? at_last : (due && (drop || at_last)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q        <= '0;
            idx_q        <= '0;
            started_q    <= 1'b0;
            classified_q <= 1'b0;
            dac_q        <= '0;
            uf_q         <= 1'b0;
            cls_q        <= CLS_ON_TIME;
            diff_q       <= '0;
        end else if (sample_en) begin
            cnt_q <= t_next;
            if (!head_full) begin
                dac_q <= '0;
                uf_q  <= 1'b1;
            end else if (started_q) begin
                dac_q <= rd_data;
                uf_q  <= 1'b0;
                if (at_last) begin
                    started_q    <= 1'b0;
                    classified_q <= 1'b0;
                    idx_q        <= '0;
                end else begin
                    idx_q <= idx_q + 32'd1;
                end
            end else begin
                if (!classified_q) begin
                    classified_q <= 1'b1;
                    cls_q        <= cls_now;
                    diff_q       <= (cls_now == CLS_ON_TIME) ? 64'd0
                                                             : time_gap(head_meta.ts, t_next);
                end
                if (!due) begin
                    dac_q <= '0;
                    uf_q  <= 1'b1;
                end else if (drop) begin
                    dac_q        <= '0;
                    uf_q         <= 1'b1;
                    idx_q        <= head_meta.len;
                    classified_q <= 1'b0;
                end else begin
                    dac_q <= rd_data;
                    uf_q  <= 1'b0;
                    if (at_last) begin
                        classified_q <= 1'b0;
                        idx_q        <= '0;
                    end else begin
                        started_q <= 1'b1;
                        idx_q     <= offset[31:0] + 32'd1;
                    end
                end
            end
        end
    end

    assign dac_iq    = dac_q;
    assign time_now  = cnt_q;
    assign underflow = uf_q;
    assign pkt_early = (cls_q == CLS_EARLY);
    assign pkt_late  = (cls_q == CLS_LATE);
    assign pkt_diff  = diff_q;

    a_r12_count_step: assert property (@(posedge clk) disable iff (rst)
        sample_en |=> (time_now == $past(time_now) + 64'd1));

    a_r12_count_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> $stable(time_now));

    a_r8_outputs_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_en |=> ($stable(dac_iq) && $stable(underflow)));

    a_r8_zero_fill: assert property (@(posedge clk) disable iff (rst)
        underflow |-> (dac_iq == 32'd0));

    a_r7_one_flag: assert property (@(posedge clk) disable iff (rst)
        !(pkt_early && pkt_late));

    a_r7_diff_zero_on_time: assert property (@(posedge clk) disable iff (rst)
        (!pkt_early && !pkt_late) |-> (pkt_diff == 64'd0));

    a_r3_wait_before_due: assert property (@(posedge clk) disable iff (rst)
        (sample_en && head_full && !started_q && !due) |=> (underflow && dac_iq == 32'd0));

endmodule

// File: rtl/tx_time_sched.sv
module tx_time_sched
    import tx_sched_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int MAX_LEN = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ts_enable,
    input  logic [31:0] s_tdata,
    input  logic        s_tvalid,
    output logic        s_tready,
    input  logic        sample_en,
    output logic [31:0] dac_iq,
    output logic [63:0] time_now,
    output logic        underflow,
    output logic        pkt_early,
    output logic        pkt_late,
    output logic [63:0] pkt_diff
);

    localparam int ADDR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic              commit;
    pkt_meta_t         commit_meta;
    logic              wr_full;
    logic [ADDR_W-1:0] rd_addr;
    logic              release_head;
    logic              head_full;
    pkt_meta_t         head_meta;
    logic [31:0]       rd_data;

    assign s_tready = !wr_full;

    txs_frame_parser #(.MAX_LEN(MAX_LEN)) u_parser (
        .clk         (clk),
        .rst         (rst),
        .s_tdata     (s_tdata),
        .s_tvalid    (s_tvalid),
        .s_tready    (s_tready),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .commit      (commit),
        .commit_meta (commit_meta)
    );

    txs_slot_bank #(.NUM_BUF(NUM_BUF), .MAX_LEN(MAX_LEN)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .commit       (commit),
        .commit_meta  (commit_meta),
        .wr_full      (wr_full),
        .rd_addr      (rd_addr),
        .release_head (release_head),
        .head_full    (head_full),
        .head_meta    (head_meta),
        .rd_data      (rd_data)
    );

    txs_playout #(.MAX_LEN(MAX_LEN)) u_play (
        .clk          (clk),
        .rst          (rst),
        .ts_enable    (ts_enable),
        .sample_en    (sample_en),
        .head_full    (head_full),
        .head_meta    (head_meta),
        .rd_data      (rd_data),
        .rd_addr      (rd_addr),
        .release_head (release_head),
        .dac_iq       (dac_iq),
        .time_now     (time_now),
        .underflow    (underflow),
        .pkt_early    (pkt_early),
        .pkt_late     (pkt_late),
        .pkt_diff     (pkt_diff)
    );

endmodule

// File: tb/tx_time_sched_tb.sv
module tx_time_sched_tb;

    localparam int NUM_BUF = 4;
    localparam int MAX_LEN = 512;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ts_enable = 1'b1;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 1'b0;
    logic        s_tready;
    logic        sample_en = 1'b0;
    logic [31:0] dac_iq;
    logic [63:0] time_now;
    logic        underflow;
    logic        pkt_early;
    logic        pkt_late;
    logic [63:0] pkt_diff;

    int checks = 0;
    int failures = 0;
    longint unsigned tb_time = 0;

    always #4 clk = ~clk;

    tx_time_sched #(.NUM_BUF(NUM_BUF), .MAX_LEN(MAX_LEN)) u_dut (
        .clk(clk), .rst(rst), .ts_enable(ts_enable),
        .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready),
        .sample_en(sample_en), .dac_iq(dac_iq), .time_now(time_now),
        .underflow(underflow), .pkt_early(pkt_early), .pkt_late(pkt_late),
        .pkt_diff(pkt_diff)
    );

    function automatic logic [31:0] smp(input int base, input int k);
        return {base[15:0], k[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (time %0d)", tag, act, exp, tb_time);
        end
    endtask

    task automatic push(input logic [31:0] w);
        s_tdata  = w;
        s_tvalid = 1'b1;
        while (!s_tready) @(negedge clk);
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic send_pkt(input longint unsigned ts, input int n, input int base);
        push(32'h7E57_C0DE);
        push(32'h5A4D_1E11);
        push(ts[31:0]);
        push(ts[63:32]);
        push(32'(n));
        for (int k = 0; k < n; k++) push(smp(base, k));
    endtask

    task automatic strobe();
        @(negedge clk);
        sample_en = 1'b1;
        @(negedge clk);
        sample_en = 1'b0;
        tb_time++;
    endtask

    task automatic chk_flags(input string tag, input logic e, input logic l, input logic [63:0] d);
        chk({tag, " early"}, 64'(pkt_early), 64'(e));
        chk({tag, " late"}, 64'(pkt_late), 64'(l));
        chk({tag, " diff"}, pkt_diff, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        longint unsigned tn;
        longint unsigned ts;
        int unsigned seed_r;
        seed_r = $urandom(32'd4711);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 time_now", time_now, 0);
        chk("R11 dac", 64'(dac_iq), 0);
        chk("R11 underflow", 64'(underflow), 0);
        chk_flags("R11", 1'b0, 1'b0, 0);
        chk("R11 ready", 64'(s_tready), 1);

        // R12 counter and R8 underflow on idle strobes
        for (int i = 0; i < 5; i++) strobe();
        chk("R12 count", time_now, 5);
        chk("R8 idle underflow", 64'(underflow), 1);
        repeat (4) @(negedge clk);
        chk("R12 hold", time_now, 5);

        // R3 / R7 early packet
        tn = tb_time + 1;
        send_pkt(tn + 14, 6, 16'h11);
        strobe();
        chk_flags("R7 early", 1'b1, 1'b0, 14);
        chk("R3 wait zero", 64'(dac_iq), 0);
        chk("R8 wait underflow", 64'(underflow), 1);
        for (int j = 1; j < 14; j++) begin
            strobe();
            chk("R3 held zero", 64'(dac_iq), 0);
        end
        for (int k = 0; k < 6; k++) begin
            strobe();
            chk("R3 on time sample", 64'(dac_iq), 64'(smp(16'h11, k)));
            chk("R3 time_now", time_now, tn + 14 + 64'(k));
            chk("R8 data clears", 64'(underflow), 0);
        end
        strobe();
        chk("R8 after packet", 64'(underflow), 1);

        // R4 late packet, trimmed
        tn = tb_time + 1;
        send_pkt(tn - 7, 10, 16'h22);
        strobe();
        chk_flags("R7 late", 1'b0, 1'b1, 7);
        chk("R4 first trimmed", 64'(dac_iq), 64'(smp(16'h22, 7)));
        strobe();
        chk("R4 next", 64'(dac_iq), 64'(smp(16'h22, 8)));
        strobe();
        chk("R4 last", 64'(dac_iq), 64'(smp(16'h22, 9)));
        strobe();
        chk("R4 done zero", 64'(dac_iq), 0);

        // R5 whole packet too late, then on-time packet behind it
        tn = tb_time + 1;
        send_pkt(tn - 8, 5, 16'h30);
        send_pkt(tn + 1, 3, 16'h31);
        strobe();
        chk("R5 dropped zero", 64'(dac_iq), 0);
        chk("R5 dropped underflow", 64'(underflow), 1);
        chk_flags("R5 late", 1'b0, 1'b1, 8);
        for (int k = 0; k < 3; k++) begin
            strobe();
            chk("R5 next packet", 64'(dac_iq), 64'(smp(16'h31, k)));
            if (k == 0) chk_flags("R7 on time", 1'b0, 1'b0, 0);
        end

        // R6 timestamping disabled
        ts_enable = 1'b0;
        send_pkt(64'd1000000, 4, 16'h40);
        for (int k = 0; k < 4; k++) begin
            strobe();
            chk("R6 immediate", 64'(dac_iq), 64'(smp(16'h40, k)));
        end
        chk_flags("R6 flags", 1'b0, 1'b0, 0);
        ts_enable = 1'b1;

        // R1 / R2 junk, partial header, bad counts
        push(32'h1234_5678);
        push(32'h7E57_C0DE);
        push(32'hDEAD_0001);
        push(32'h5A4D_1E11);
        push(32'h7E57_C0DE); push(32'h5A4D_1E11);
        push(32'd5); push(32'd0); push(32'd0);
        push(32'h0000_0001);
        push(32'h7E57_C0DE); push(32'h5A4D_1E11);
        push(32'd5); push(32'd0); push(32'(MAX_LEN + 1));
        push(32'h0000_0002); push(32'h0000_0003);
        tn = tb_time + 1;
        send_pkt(tn + 2, 2, 16'h44);
        strobe();
        chk("R1 junk ignored", 64'(dac_iq), 0);
        chk_flags("R2 bad headers skipped", 1'b1, 1'b0, 2);
        strobe();
        chk("R2 still waiting", 64'(dac_iq), 0);
        strobe();
        chk("R1 valid packet", 64'(dac_iq), 64'(smp(16'h44, 0)));
        strobe();
        chk("R1 valid packet 2", 64'(dac_iq), 64'(smp(16'h44, 1)));
        strobe();
        chk("R2 nothing more", 64'(dac_iq), 0);

        // R10 / R9 fill all buffers
        ts_enable = 1'b0;
        for (int p = 0; p < NUM_BUF; p++) send_pkt(0, 2, 16'h50 + p);
        chk("R10 ready low", 64'(s_tready), 0);
        strobe();
        chk("R9 first pkt", 64'(dac_iq), 64'(smp(16'h50, 0)));
        chk("R10 still low", 64'(s_tready), 0);
        strobe();
        chk("R9 first pkt end", 64'(dac_iq), 64'(smp(16'h50, 1)));
        chk("R10 ready back", 64'(s_tready), 1);
        send_pkt(0, 2, 16'h54);
        for (int p = 1; p <= NUM_BUF; p++) begin
            for (int k = 0; k < 2; k++) begin
                strobe();
                chk("R9 order", 64'(dac_iq), 64'(smp(16'h50 + p, k)));
            end
        end
        strobe();
        chk("R9 drained", 64'(dac_iq), 0);
        ts_enable = 1'b1;

        // Random mix of early, late, on-time and dropped packets (R3 R4 R5 R7)
        for (int it = 0; it < 40; it++) begin
            int n;
            int delta;
            int span;
            longint unsigned t;
            n = 1 + int'($urandom % 16);
            delta = int'($urandom % 41) - 20;
            tn = tb_time + 1;
            ts = longint'(tn) + longint'(delta);
            send_pkt(ts, n, 16'h100 + it);
            span = ((delta > 0) ? delta : 0) + n + 1;
            for (int j = 0; j < span; j++) begin
                logic [31:0] exp;
                strobe();
                t = tn + longint'(j);
                exp = (t >= ts && (t - ts) < longint'(n)) ? smp(16'h100 + it, int'(t - ts)) : 32'd0;
                chk("R3/R4/R5 random sample", 64'(dac_iq), 64'(exp));
                chk("R8 random underflow", 64'(underflow), 64'(exp == 32'd0));
                if (j == 0) begin
                    if (delta > 0)      chk_flags("R7 random", 1'b1, 1'b0, 64'(delta));
                    else if (delta < 0) chk_flags("R7 random", 1'b0, 1'b1, 64'(-delta));
                    else                chk_flags("R7 random", 1'b0, 1'b0, 0);
                end
            end
        end
        chk("R12 final count", time_now, tb_time);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule